// File: doc/BRIEF.md
# Power-On Strap Capture and Test-Rate Clock Fan-Out

This block sits between a reference oscillator and several groups of clock outputs. While power-on reset is held, two shared pads are inputs. Their levels are captured, together with two dedicated select inputs, into a 4-bit configuration register. That register stops loading on the first reference edge after reset ends. One cycle later the shared pads are turned around and begin to drive clocks.

The captured straps pick one of two modes. In the first, a production test mode, every output group is driven from the reference clock at a fixed ratio. The full-rate group and the shared pads carry the reference itself. The half-rate group carries the reference divided by two, and the quarter-rate group carries it divided by four. Both divided clocks come from one free-running down-counter, so their rising edges line up. Any other strap combination routes each group to a placeholder normal-mode clock input instead.

Top module: `strap_clk_gen`

## Requirements
- R1: While por_rst is high the configuration register loads on every ref_clk rising edge. Bit 0 comes from pad_in[0], bit 1 from pad_in[1], bit 2 from fsel_i[0] and bit 3 from fsel_i[1]. The value present at the last edge with por_rst high is the one kept.
- R2: From the first edge with por_rst low until the next reset, changes on pad_in and fsel_i do not change the selected mode or any output.
- R3: pad_oe is 0 while por_rst is high, stays 0 after the first edge with por_rst low, and becomes all ones after the second such edge.
- R4: While pad_oe is 0, pad_out and every clock output group are held at 0.
- R5: Test mode is selected exactly when bit 0 = 1, bit 1 = 1 and bit 2 = 0. Bit 3 has no effect on the mode.
- R6: In test mode, clk_ref_o and pad_out follow ref_clk: high while ref_clk is high and low while it is low.
- R7: In test mode, clk_half_o toggles on every ref_clk rising edge (reference divided by two, 50% duty). After the k-th edge following reset release it equals bit 0 of (3 - k) mod 4.
- R8: In test mode, clk_qtr_o is the reference divided by four: bit 1 of (3 - k) mod 4. Every rising edge of clk_qtr_o coincides with a rising edge of clk_half_o.
- R9: Outside test mode, clk_ref_o and pad_out follow norm_clk_i[0], clk_half_o follows norm_clk_i[1], and clk_qtr_o follows norm_clk_i[2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock (crystal or external) |
| por_rst | input | 1 | Power-on reset, active high |
| pad_in | input | 2 | Input side of the two shared strap/clock pads |
| pad_out | output | 2 | Output side of the shared pads |
| pad_oe | output | 2 | Output enables for the shared pads |
| fsel_i | input | 2 | Dedicated frequency-select straps |
| norm_clk_i | input | 3 | Placeholder normal-mode clocks, one per group |
| clk_ref_o | output | N_REF | Full-rate clock group |
| clk_half_o | output | N_HALF | Half-rate clock group |
| clk_qtr_o | output | N_QTR | Quarter-rate clock group |

## Verification
The hardest case to reach from the ports is proving which strap value the register froze. The register is never visible. Only the mode it selects shows at the outputs, and only after the pads turn around. The stimulus holds reset with non-test straps and switches to the test pattern for exactly the final reset edge. In the same half cycle that reset falls, it swaps the straps back. A test-rate pattern then shows that the last reset edge was sampled and that post-reset changes were ignored. A table of strap combinations, including the spare bit set in and out of test mode, walks each reset cycle by cycle against a counter model kept in the bench.

// File: rtl/strap_pkg.sv
package strap_pkg;

  localparam int CFG_W = 4;

  typedef struct packed {
    logic spare;
    logic fs2;
    logic fs1;
    logic fs0;
  } strap_cfg_t;

  typedef enum logic [1:0] {
    GRP_FULL = 2'd0,
    GRP_HALF = 2'd1,
    GRP_QTR  = 2'd2
  } grp_e;

  localparam int N_GRP = 3;

  // Production test combination: fs0 and fs1 high, fs2 low; spare ignored.
  function automatic logic is_test_mode(strap_cfg_t c);
    return c.fs0 & c.fs1 & ~c.fs2;
  endfunction

  // Down-counter step; its bit i is the reference divided by 2^(i+1),
  // and all bits rise together on the wrap from zero.
  function automatic logic [7:0] div_step(logic [7:0] c);
    return c - 8'd1;
  endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
#(
  parameter int SETTLE = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] strap_i,
  output strap_cfg_t cfg_o,
  output logic       drive_o
);

  strap_cfg_t        cfg_q;
  logic [SETTLE-1:0] lag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= strap_cfg_t'(strap_i);
      lag_q <= '0;
    end else begin
      lag_q <= {lag_q[SETTLE-2:0], 1'b1};
    end
  end

  assign cfg_o   = cfg_q;
  assign drive_o = lag_q[SETTLE-1];

endmodule

// File: rtl/ref_div.sv
module ref_div
  import strap_pkg::*;
#(
  parameter int DIV_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  output logic [DIV_W-1:0] taps_o
);

  logic [DIV_W-1:0] cnt_q;
  logic [7:0]       nxt;

  assign nxt = div_step(8'(cnt_q));

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= nxt[DIV_W-1:0];
  end

  assign taps_o = cnt_q;

endmodule

// File: rtl/clk_sel.sv
module clk_sel #(
  parameter int W = 1
) (
  input  logic         en,
  input  logic         use_test,
  input  logic         test_clk,
  input  logic         norm_clk,
  output logic [W-1:0] clk_o
);

  logic src;

  assign src = use_test ? test_clk : norm_clk;

  for (genvar i = 0; i < W; i++) begin : g_fan
    assign clk_o[i] = en & src;
  end

endmodule

// File: rtl/strap_clk_gen.sv
module strap_clk_gen
  import strap_pkg::*;
#(
  parameter int N_REF  = 2,
  parameter int N_HALF = 3,
  parameter int N_QTR  = 7
) (
  input  logic              ref_clk,
  input  logic              por_rst,
  input  logic [1:0]        pad_in,
  output logic [1:0]        pad_out,
  output logic [1:0]        pad_oe,
  input  logic [1:0]        fsel_i,
  input  logic [N_GRP-1:0]  norm_clk_i,
  output logic [N_REF-1:0]  clk_ref_o,
  output logic [N_HALF-1:0] clk_half_o,
  output logic [N_QTR-1:0]  clk_qtr_o
);

  localparam int N_PAD = 2;
  localparam int DIV_W = 2;

  strap_cfg_t       cfg_q;
  logic             test_mode;
  logic             drive_en;
  logic [DIV_W-1:0] div_taps;

  strap_capture #(.SETTLE(2)) u_cap (
    .clk     (ref_clk),
    .rst     (por_rst),
    .strap_i ({fsel_i, pad_in}),
    .cfg_o   (cfg_q),
    .drive_o (drive_en)
  );

  assign test_mode = is_test_mode(cfg_q);

  ref_div #(.DIV_W(DIV_W)) u_div (
    .clk    (ref_clk),
    .rst    (por_rst),
    .taps_o (div_taps)
  );

  clk_sel #(.W(N_REF)) u_full (
    .en(drive_en), .use_test(test_mode), .test_clk(ref_clk),
    .norm_clk(norm_clk_i[GRP_FULL]), .clk_o(clk_ref_o));

  clk_sel #(.W(N_PAD)) u_pad (
    .en(drive_en), .use_test(test_mode), .test_clk(ref_clk),
    .norm_clk(norm_clk_i[GRP_FULL]), .clk_o(pad_out));

  clk_sel #(.W(N_HALF)) u_half (
    .en(drive_en), .use_test(test_mode), .test_clk(div_taps[0]),
    .norm_clk(norm_clk_i[GRP_HALF]), .clk_o(clk_half_o));

  clk_sel #(.W(N_QTR)) u_qtr (
    .en(drive_en), .use_test(test_mode), .test_clk(div_taps[1]),
    .norm_clk(norm_clk_i[GRP_QTR]), .clk_o(clk_qtr_o));

  assign pad_oe = {N_PAD{drive_en}};

endmodule

// File: rtl/strap_clk_chk.sv
module strap_clk_chk #(
  parameter int N_REF  = 2,
  parameter int N_HALF = 3,
  parameter int N_QTR  = 7
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        pad_oe,
  input logic [1:0]        pad_out,
  input logic [N_REF-1:0]  clk_ref,
  input logic [N_HALF-1:0] clk_half,
  input logic [N_QTR-1:0]  clk_qtr,
  input logic [3:0]        cfg,
  input logic              test_mode
);

  // R2
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> $stable(cfg));

  // R3
  oe_lag_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |=> (pad_oe == 2'b00) ##1 (pad_oe == 2'b11));

  // R4
  quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_oe == 2'b00) |-> (clk_half == '0 && clk_qtr == '0 &&
                           pad_out == '0 && clk_ref == '0));

  // R7
  half_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (test_mode && pad_oe[0] && $past(pad_oe[0])) |->
      (clk_half[0] != $past(clk_half[0])));

  // R8
  qtr_align_chk: assert property (@(posedge clk) disable iff (rst)
    (test_mode && $past(pad_oe[0]) && $rose(clk_qtr[0])) |-> $rose(clk_half[0]));

endmodule

bind strap_clk_gen strap_clk_chk #(
  .N_REF(N_REF), .N_HALF(N_HALF), .N_QTR(N_QTR)
) u_chk (
  .clk       (ref_clk),
  .rst       (por_rst),
  .pad_oe    (pad_oe),
  .pad_out   (pad_out),
  .clk_ref   (clk_ref_o),
  .clk_half  (clk_half_o),
  .clk_qtr   (clk_qtr_o),
  .cfg       (cfg_q),
  .test_mode (test_mode)
);

// File: tb/test_strap_clk_gen.sv
`timescale 1ns/1ps
module test_strap_clk_gen;

  localparam int N_REF = 2, N_HALF = 3, N_QTR = 7;

  logic              ref_clk = 1'b0;
  logic              por_rst = 1'b1;
  logic [1:0]        pad_in = '0;
  logic [1:0]        fsel_i = '0;
  logic [2:0]        norm_clk_i = 3'b101;
  logic [1:0]        pad_out, pad_oe;
  logic [N_REF-1:0]  clk_ref_o;
  logic [N_HALF-1:0] clk_half_o;
  logic [N_QTR-1:0]  clk_qtr_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 ref_clk = ~ref_clk;

  strap_clk_gen #(.N_REF(N_REF), .N_HALF(N_HALF), .N_QTR(N_QTR)) i_strap_clk_gen (
    .ref_clk, .por_rst, .pad_in, .pad_out, .pad_oe, .fsel_i,
    .norm_clk_i, .clk_ref_o, .clk_half_o, .clk_qtr_o);

  // {fsel_i[1], fsel_i[0], pad_in[1], pad_in[0], expect_test}
  localparam logic [4:0] VEC [8] = '{
    5'b0011_1, 5'b1011_1, 5'b0111_0, 5'b0001_0,
    5'b0010_0, 5'b1111_0, 5'b0000_0, 5'b1010_0 };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic hold_reset(input logic [3:0] s);
    @(negedge ref_clk);
    por_rst = 1'b1;
    pad_in  = s[1:0];
    fsel_i  = s[3:2];
    repeat (3) @(posedge ref_clk);
  endtask

  // Check outputs after edge k (k = 0 is the first edge with reset low).
  task automatic check_after(input int k, input bit tm, input string tag);
    logic act;
    int c;
    logic h, q, f;
    act = (k >= 1);
    c = (400 + 3 - k) % 4;
    h = tm ? c[0] : norm_clk_i[1];
    q = tm ? c[1] : norm_clk_i[2];
    f = tm ? 1'b1 : norm_clk_i[0];
    #2;
    chk({"R3 ", tag}, pad_oe, act ? 2'b11 : 2'b00);
    chk({"R7/R9 ", tag}, clk_half_o, act ? {N_HALF{h}} : '0);
    chk({"R8/R9 ", tag}, clk_qtr_o, act ? {N_QTR{q}} : '0);
    chk({"R6/R9 ", tag}, clk_ref_o, act ? {N_REF{f}} : '0);
    chk({"R6/R4 ", tag}, pad_out, act ? {2{f}} : '0);
    @(negedge ref_clk); #2;
    f = tm ? 1'b0 : norm_clk_i[0];
    chk({"R6/R9 low ", tag}, clk_ref_o, act ? {N_REF{f}} : '0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // Reset state: R3, R4
    repeat (3) @(posedge ref_clk);
    #2;
    chk("R3 oe in reset", pad_oe, 2'b00);
    chk("R4 quiet in reset", {pad_out, clk_ref_o, clk_half_o, clk_qtr_o}, '0);

    // Table walk: R1, R5, R6..R9
    for (int v = 0; v < 8; v++) begin
      hold_reset(VEC[v][4:1]);
      @(negedge ref_clk); por_rst = 1'b0;
      for (int k = 0; k < 9; k++) begin
        @(posedge ref_clk);
        check_after(k, VEC[v][0], $sformatf("R5 vec%0d k%0d", v, k));
      end
    end

    // R1/R2: only the last reset edge counts; later strap changes ignored.
    hold_reset(4'b0000);
    @(negedge ref_clk); pad_in = 2'b11; fsel_i = 2'b00;
    @(negedge ref_clk); por_rst = 1'b0; pad_in = 2'b00; fsel_i = 2'b01;
    for (int k = 0; k < 6; k++) begin
      @(posedge ref_clk);
      check_after(k, 1'b1, $sformatf("R1 R2 late k%0d", k));
    end

    // R2 reverse: non-test capture, test straps applied after release.
    hold_reset(4'b0100);
    @(negedge ref_clk); por_rst = 1'b0; pad_in = 2'b11; fsel_i = 2'b00;
    norm_clk_i = 3'b010;
    for (int k = 0; k < 6; k++) begin
      @(posedge ref_clk);
      check_after(k, 1'b0, $sformatf("R2 ignore k%0d", k));
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule